// File: doc/BRIEF.md
# Condition Register Logic Unit

This block is the execution stage for the operations of a processor that act on its 32-bit condition register. The register is treated as eight 4-bit fields, numbered from the most significant end. On each clock the stage takes an opcode, the instruction's selector fields, two 64-bit operands and the current condition register. It registers the result of the chosen operation. The operations are: move to the condition register under a field mask, move from it (all fields or selected fields), copy one field to another, a two-input logical operation on single bits, and integer select.

There are three results: a 64-bit integer result, a 4-bit field result and a complete 32-bit condition register image. Each result has its own valid flag. A flag rises only for the operations that really write that result. When a flag is low, its data output reads zero. Downstream write-back logic can therefore use the flags directly as write requests. Decode, register-file access and pipeline flow control are outside the block.

Top module: `crlu_top`

## Requirements
- R1: Field f (0..7) of the condition register occupies bits (7-f)*4+3 down to (7-f)*4, so field 0 is bits 31:28. CR bit n (0..31) is bit 31-n of `cr_i`.
- R2: Integer select (opcode 5) returns `opa_i` when CR bit `bsel_c_i` is 1 and `opb_i` when it is 0. The top three selector bits name the field and the low two bits name the bit inside it.
- R3: The logical operation (opcode 4) forms its result bit as `lut_i[2*A+B]`, where A is CR bit `bsel_a_i` and B is CR bit `bsel_b_i`. With `lut_i` = 4'b0110 this is A XOR B.
- R4: The logical operation writes only CR bit `bsel_t_i`. The full image equals `cr_i` in the other 31 bits, and the field result is the updated field `bsel_t_i[4:2]`.
- R5: Field copy (opcode 3) puts field `fld_src_i` into field `fld_dst_i` of the full image and leaves the other seven fields as in `cr_i`. The field result is the copied field.
- R6: Move to CR (opcode 1) builds the full image so that nibble k (bits 4k+3:4k) comes from `opa_i` when `fxm_i[k]` is 1 and from `cr_i` otherwise.
- R7: Move from CR (opcode 2) with `one_fld_i` = 0 returns `cr_i` in bits 31:0 of the integer result, with bits 63:32 zero.
- R8: Move from CR with `one_fld_i` = 1 returns nibble k of `cr_i` where `fxm_i[k]` is 1 and zero elsewhere. Bits 63:32 are zero.
- R9: Encoding 0 = no-op, 1 = move to CR, 2 = move from CR, 3 = field copy, 4 = logical, 5 = integer select. `res_ok_o` rises only for 2 and 5. `fld_ok_o` rises only for 3 and 4. `cr_ok_o` rises only for 1, 3 and 4. A data output whose flag is low reads zero.
- R10: Opcodes 0 and 6..15 raise no valid flag, and all data outputs are zero.
- R11: All outputs are registered. They reflect the inputs present at the previous rising clock edge, and they are zero while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| lut_i | input | 4 | Truth table for the logical operation |
| bsel_a_i | input | 5 | First source CR bit (logical op) |
| bsel_b_i | input | 5 | Second source CR bit (logical op) |
| bsel_t_i | input | 5 | Target CR bit (logical op) |
| bsel_c_i | input | 5 | Condition CR bit (integer select) |
| fld_dst_i | input | 3 | Destination field (field copy) |
| fld_src_i | input | 3 | Source field (field copy) |
| fxm_i | input | 8 | Nibble mask for move to / from CR |
| one_fld_i | input | 1 | Selects masked form of move from CR |
| opa_i | input | 64 | Operand a |
| opb_i | input | 64 | Operand b |
| cr_i | input | 32 | Current condition register |
| res_o | output | 64 | Integer result |
| res_ok_o | output | 1 | Integer result valid |
| fld_o | output | 4 | Field result |
| fld_ok_o | output | 1 | Field result valid |
| cr_o | output | 32 | Full condition register image |
| cr_ok_o | output | 1 | Full image valid |

## Verification
Every result, flag and data output alike, is due exactly one rising edge after its inputs are applied. No result takes longer, since the stage has one register level.

The bench changes the inputs on the falling edge and reads all six outputs on the following falling edge. This is half a period after the capturing edge, so both the capture and the comparison stay clear of the edge. One extra probe reads the outputs just after an input change. This confirms that the old result still holds before the edge.

// File: rtl/crlu_pkg.sv
package crlu_pkg;
  typedef enum logic [3:0] {
    CRLU_NOP  = 4'd0,
    CRLU_MTCR = 4'd1,
    CRLU_MFCR = 4'd2,
    CRLU_MCRF = 4'd3,
    CRLU_CROP = 4'd4,
    CRLU_ISEL = 4'd5
  } crlu_op_e;
endpackage

// File: rtl/crlu_field_ops.sv
module crlu_field_ops #(
  parameter int NFLD = 8,
  parameter int FW   = 4,
  parameter int XLEN = 64
) (
  input  logic [NFLD*FW-1:0]         cr,
  input  logic [NFLD-1:0]            fxm,
  input  logic                       one_fld,
  input  logic [$clog2(NFLD)-1:0]    src_fld,
  input  logic [$clog2(NFLD)-1:0]    dst_fld,
  input  logic [XLEN-1:0]            opa,
  output logic [NFLD*FW-1:0]         mtcr_img,
  output logic [XLEN-1:0]            mfcr_res,
  output logic [NFLD*FW-1:0]         mcrf_img,
  output logic [FW-1:0]              mcrf_fld
);
  localparam int CRW = NFLD * FW;

  logic [CRW-1:0] masked_cr;

  // nibble addressed by the source field number, counted from the MSB end
  always_comb begin
    mcrf_fld = '0;
    for (int k = 0; k < NFLD; k++) begin
      if (k == NFLD - 1 - int'(src_fld)) mcrf_fld = cr[k*FW +: FW];
    end
  end

  for (genvar k = 0; k < NFLD; k++) begin : g_nib
    assign mtcr_img[k*FW +: FW]  = fxm[k] ? opa[k*FW +: FW] : cr[k*FW +: FW];
    assign masked_cr[k*FW +: FW] = fxm[k] ? cr[k*FW +: FW] : '0;
    assign mcrf_img[k*FW +: FW]  = (k == NFLD - 1 - int'(dst_fld)) ? mcrf_fld
                                                                  : cr[k*FW +: FW];
  end

  assign mfcr_res = one_fld ? {{(XLEN-CRW){1'b0}}, masked_cr}
                            : {{(XLEN-CRW){1'b0}}, cr};
endmodule

// File: rtl/crlu_bit_ops.sv
module crlu_bit_ops #(
  parameter int NFLD = 8,
  parameter int FW   = 4,
  parameter int XLEN = 64
) (
  input  logic [NFLD*FW-1:0]            cr,
  input  logic [$clog2(NFLD*FW)-1:0]    bsel_a,
  input  logic [$clog2(NFLD*FW)-1:0]    bsel_b,
  input  logic [$clog2(NFLD*FW)-1:0]    bsel_t,
  input  logic [$clog2(NFLD*FW)-1:0]    bsel_c,
  input  logic [3:0]                    lut,
  input  logic [XLEN-1:0]               opa,
  input  logic [XLEN-1:0]               opb,
  output logic [XLEN-1:0]               isel_res,
  output logic [NFLD*FW-1:0]            crop_img,
  output logic [FW-1:0]                 crop_fld
);
  localparam int CRW = NFLD * FW;
  localparam int BSW = $clog2(CRW);
  localparam int FSW = $clog2(NFLD);

  logic [BSW-1:0] idx_a, idx_b, idx_t, idx_c;
  logic           bit_a, bit_b, bit_c, bit_r;
  logic [FSW-1:0] t_fld;

  // big-endian bit number n lives at little-endian position CRW-1-n
  assign idx_a = BSW'(CRW - 1) - bsel_a;
  assign idx_b = BSW'(CRW - 1) - bsel_b;
  assign idx_t = BSW'(CRW - 1) - bsel_t;
  assign idx_c = BSW'(CRW - 1) - bsel_c;

  assign bit_a = cr[idx_a];
  assign bit_b = cr[idx_b];
  assign bit_c = cr[idx_c];
  assign bit_r = lut[{bit_a, bit_b}];

  assign isel_res = bit_c ? opa : opb;
  assign t_fld    = bsel_t[BSW-1 -: FSW];

  always_comb begin
    for (int j = 0; j < CRW; j++) begin
      crop_img[j] = (BSW'(j) == idx_t) ? bit_r : cr[j];
    end
  end

  always_comb begin
    crop_fld = '0;
    for (int k = 0; k < NFLD; k++) begin
      if (k == NFLD - 1 - int'(t_fld)) crop_fld = crop_img[k*FW +: FW];
    end
  end
endmodule

// File: rtl/crlu_top.sv
module crlu_top
  import crlu_pkg::*;
#(
  parameter int NFLD = 8,
  parameter int FW   = 4,
  parameter int XLEN = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [3:0]                 op_i,
  input  logic [3:0]                 lut_i,
  input  logic [$clog2(NFLD*FW)-1:0] bsel_a_i,
  input  logic [$clog2(NFLD*FW)-1:0] bsel_b_i,
  input  logic [$clog2(NFLD*FW)-1:0] bsel_t_i,
  input  logic [$clog2(NFLD*FW)-1:0] bsel_c_i,
  input  logic [$clog2(NFLD)-1:0]    fld_dst_i,
  input  logic [$clog2(NFLD)-1:0]    fld_src_i,
  input  logic [NFLD-1:0]            fxm_i,
  input  logic                       one_fld_i,
  input  logic [XLEN-1:0]            opa_i,
  input  logic [XLEN-1:0]            opb_i,
  input  logic [NFLD*FW-1:0]         cr_i,
  output logic [XLEN-1:0]            res_o,
  output logic                       res_ok_o,
  output logic [FW-1:0]              fld_o,
  output logic                       fld_ok_o,
  output logic [NFLD*FW-1:0]         cr_o,
  output logic                       cr_ok_o
);
  localparam int CRW = NFLD * FW;

  crlu_op_e        opc;
  logic [CRW-1:0]  mtcr_img, mcrf_img, crop_img;
  logic [XLEN-1:0] mfcr_res, isel_res;
  logic [FW-1:0]   mcrf_fld, crop_fld;

  logic [XLEN-1:0] res_d;
  logic [FW-1:0]   fld_d;
  logic [CRW-1:0]  cr_d;
  logic            res_ok_d, fld_ok_d, cr_ok_d;

  assign opc = crlu_op_e'(op_i);

  crlu_field_ops #(.NFLD(NFLD), .FW(FW), .XLEN(XLEN)) u_field (
    .cr       (cr_i),
    .fxm      (fxm_i),
    .one_fld  (one_fld_i),
    .src_fld  (fld_src_i),
    .dst_fld  (fld_dst_i),
    .opa      (opa_i),
    .mtcr_img (mtcr_img),
    .mfcr_res (mfcr_res),
    .mcrf_img (mcrf_img),
    .mcrf_fld (mcrf_fld)
  );

  crlu_bit_ops #(.NFLD(NFLD), .FW(FW), .XLEN(XLEN)) u_bit (
    .cr       (cr_i),
    .bsel_a   (bsel_a_i),
    .bsel_b   (bsel_b_i),
    .bsel_t   (bsel_t_i),
    .bsel_c   (bsel_c_i),
    .lut      (lut_i),
    .opa      (opa_i),
    .opb      (opb_i),
    .isel_res (isel_res),
    .crop_img (crop_img),
    .crop_fld (crop_fld)
  );

  // next-state selection
  always_comb begin
    res_d    = '0;
    fld_d    = '0;
    cr_d     = '0;
    res_ok_d = 1'b0;
    fld_ok_d = 1'b0;
    cr_ok_d  = 1'b0;
    case (opc)
      CRLU_MTCR: begin
        cr_d    = mtcr_img;
        cr_ok_d = 1'b1;
      end
      CRLU_MFCR: begin
        res_d    = mfcr_res;
        res_ok_d = 1'b1;
      end
      CRLU_MCRF: begin
        cr_d     = mcrf_img;
        fld_d    = mcrf_fld;
        cr_ok_d  = 1'b1;
        fld_ok_d = 1'b1;
      end
      CRLU_CROP: begin
        cr_d     = crop_img;
        fld_d    = crop_fld;
        cr_ok_d  = 1'b1;
        fld_ok_d = 1'b1;
      end
      CRLU_ISEL: begin
        res_d    = isel_res;
        res_ok_d = 1'b1;
      end
      default: ;
    endcase
  end

  // result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_o    <= '0;
      fld_o    <= '0;
      cr_o     <= '0;
      res_ok_o <= 1'b0;
      fld_ok_o <= 1'b0;
      cr_ok_o  <= 1'b0;
    end else begin
      res_o    <= res_d;
      fld_o    <= fld_d;
      cr_o     <= cr_d;
      res_ok_o <= res_ok_d;
      fld_ok_o <= fld_ok_d;
      cr_ok_o  <= cr_ok_d;
    end
  end

  AST_RES_OK_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    res_ok_o |-> ($past(op_i) == 4'd2 || $past(op_i) == 4'd5)); // R9
  AST_FLD_OK_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    fld_ok_o |-> ($past(op_i) == 4'd3 || $past(op_i) == 4'd4)); // R9
  AST_CR_OK_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    cr_ok_o |-> ($past(op_i) == 4'd1 || $past(op_i) == 4'd3 || $past(op_i) == 4'd4)); // R10
  AST_MFCR_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_ok_o && $past(op_i) == 4'd2) |-> (res_o[XLEN-1:CRW] == '0)); // R7
  AST_CROP_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_ok_o && $past(op_i) == 4'd4) |-> ($countones(cr_o ^ $past(cr_i)) <= 1)); // R4
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !res_ok_o |-> (res_o == '0)); // R9
endmodule

// File: tb/crlu_top_tb.sv
module crlu_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  op, lut;
  logic [4:0]  ba, bb, bt, bc;
  logic [2:0]  fdst, fsrc;
  logic [7:0]  fxm;
  logic        one;
  logic [63:0] opa, opb;
  logic [31:0] cr;
  logic [63:0] res;
  logic        res_ok, fld_ok, cr_ok;
  logic [3:0]  fld;
  logic [31:0] cro;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  crlu_top u_dut (
    .clk(clk), .rst_n(rst_n), .op_i(op), .lut_i(lut),
    .bsel_a_i(ba), .bsel_b_i(bb), .bsel_t_i(bt), .bsel_c_i(bc),
    .fld_dst_i(fdst), .fld_src_i(fsrc), .fxm_i(fxm), .one_fld_i(one),
    .opa_i(opa), .opb_i(opb), .cr_i(cr),
    .res_o(res), .res_ok_o(res_ok), .fld_o(fld), .fld_ok_o(fld_ok),
    .cr_o(cro), .cr_ok_o(cr_ok)
  );

  function automatic logic [3:0] fget(input logic [31:0] c, input int f);
    return c[(7-f)*4 +: 4];
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // apply current inputs, wait one edge, compare against the requirement model
  task automatic run(input string req);
    logic [63:0] e_res;
    logic [3:0]  e_fld;
    logic [31:0] e_cr;
    logic        e_rok, e_fok, e_cok, a, b, r;
    e_res = '0; e_fld = '0; e_cr = '0; e_rok = 0; e_fok = 0; e_cok = 0;
    case (op)
      4'd1: begin
        e_cok = 1;
        for (int k = 0; k < 8; k++)
          e_cr[k*4 +: 4] = fxm[k] ? opa[k*4 +: 4] : cr[k*4 +: 4];
      end
      4'd2: begin
        e_rok = 1;
        for (int k = 0; k < 8; k++)
          e_res[k*4 +: 4] = (!one || fxm[k]) ? cr[k*4 +: 4] : 4'h0;
      end
      4'd3: begin
        e_cok = 1; e_fok = 1;
        e_fld = fget(cr, int'(fsrc));
        e_cr = cr;
        e_cr[(7-int'(fdst))*4 +: 4] = e_fld;
      end
      4'd4: begin
        e_cok = 1; e_fok = 1;
        a = cr[31-int'(ba)];
        b = cr[31-int'(bb)];
        r = lut[2*int'(a) + int'(b)];
        e_cr = cr;
        e_cr[31-int'(bt)] = r;
        e_fld = fget(e_cr, int'(bt) / 4);
      end
      4'd5: begin
        e_rok = 1;
        e_res = cr[31-int'(bc)] ? opa : opb;
      end
      default: ;
    endcase
    @(negedge clk);
    chk({req, " res"}, res, e_res);
    chk({req, " res_ok"}, {63'b0, res_ok}, {63'b0, e_rok});
    chk({req, " fld"}, {60'b0, fld}, {60'b0, e_fld});
    chk({req, " fld_ok"}, {63'b0, fld_ok}, {63'b0, e_fok});
    chk({req, " cr"}, {32'b0, cro}, {32'b0, e_cr});
    chk({req, " cr_ok"}, {63'b0, cr_ok}, {63'b0, e_cok});
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; op = 4'd5; lut = 0; ba = 0; bb = 0; bt = 0; bc = 0;
    fdst = 0; fsrc = 0; fxm = 0; one = 0;
    opa = 64'hFFFF_FFFF_FFFF_FFFF; opb = 64'h1; cr = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    // R11: reset holds every output at zero
    chk("R11 reset res", res, 64'h0);
    chk("R11 reset flags", {61'b0, res_ok, fld_ok, cr_ok}, 64'h0);
    chk("R11 reset cr", {32'b0, cro}, 64'h0);
    op = 4'd0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 R2: integer select over every CR bit, both polarities
    op = 4'd5;
    opa = 64'hA5A5_0000_1234_5678; opb = 64'h0F0F_F0F0_8765_4321;
    for (int n = 0; n < 32; n++) begin
      bc = 5'(n);
      cr = 32'h8000_0000 >> n;
      run("R2 isel set");
      cr = ~(32'h8000_0000 >> n);
      run("R1 isel clear");
    end

    // R11: output does not move before the capturing edge
    cr = 32'h0; bc = 5'd0;
    run("R11 prime");
    cr = 32'h8000_0000;
    #1;
    chk("R11 latency", res, opb);
    @(negedge clk);

    // R3 R4: every truth table, all target bits, varied sources
    op = 4'd4;
    for (int l = 0; l < 16; l++) begin
      for (int t = 0; t < 32; t++) begin
        lut = 4'(l); bt = 5'(t);
        ba = 5'((t * 7 + l) % 32); bb = 5'((t * 13 + 3) % 32);
        cr = {$urandom} ^ (32'h1 << t);
        run(l == 6 ? "R3 crop xor" : "R4 crop");
      end
    end

    // R5: all field copy pairs
    op = 4'd3;
    for (int d = 0; d < 8; d++)
      for (int s = 0; s < 8; s++) begin
        fdst = 3'(d); fsrc = 3'(s);
        cr = 32'h0123_4567 ^ {$urandom};
        run("R5 mcrf");
      end

    // R6: every nibble mask
    op = 4'd1;
    for (int m = 0; m < 256; m++) begin
      fxm = 8'(m);
      opa = {$urandom, $urandom}; cr = $urandom;
      run("R6 mtcr");
    end

    // R7: whole move from CR
    op = 4'd2; one = 0; fxm = 8'hFF;
    for (int p = 0; p < 6; p++) begin
      cr = (p == 0) ? 32'hFFFF_FFFF : $urandom;
      run("R7 mfcr all");
    end

    // R8: one-field form, each single nibble and a few others
    one = 1;
    for (int k = 0; k < 8; k++) begin
      fxm = 8'h1 << k; cr = $urandom;
      run("R8 mfcr one");
    end
    fxm = 8'h00; cr = 32'hFFFF_FFFF;
    run("R8 mfcr none");

    // R9 R10: no-op and unused codes raise nothing
    fxm = 8'hFF; opa = '1; opb = '1; cr = '1; lut = 4'hF;
    for (int c = 0; c < 16; c++) begin
      if (c == 0 || c > 5) begin
        op = 4'(c);
        run("R10 unused");
      end
    end
    op = 4'd1;
    run("R9 flags");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule